// File: doc/BRIEF.md
# Copper PHY bring-up sequencer

This block brings a gigabit copper Ethernet PHY from power-up to a resolved link without software. After a start pulse it walks a fixed list of management-register transactions. Each one is a read followed by a write of the modified value, a plain write, or a repeated read. It hands each transaction to a separate management-frame engine through a request/acknowledge port, one at a time. That engine is not part of this block.

The sequence selects register page 0 and turns on every pause and speed advertisement. It enables and restarts auto-negotiation and then issues a soft reset, re-reading the control register until the self-clearing reset bit drops. When the transmit-delay input is low, it also visits page 2 to turn off the PHY-side transmit clock delay and keep the receive delay on. It then waits for auto-negotiation to finish, samples the latched auto-negotiation error flag and waits until speed and duplex are resolved. It ends by reporting the speed code. Every polling loop is limited by a parameterised number of reads. If a loop runs out of reads, the block stops with an error.

Top module: `phy_init_seq`

## Requirements
- R1: A request (req_o high) keeps we_o, reg_addr_o and wdata_o stable until the cycle in which ack_i is high. Only one transaction is in flight at any time. phy_addr_o always carries the PHY_ADDR parameter.
- R2: The first transaction after an accepted start writes 0x0000 to register 22, which selects the page. Register 21 is only accessed after register 22 was last written with 2. Register 1 is only accessed after register 22 was last written with 0.
- R3: Register 4 is read and written back as read | 0x0DE0. Register 9 is then read and written back as read | 0x0300.
- R4: Register 0 is read and written back as read | 0x1200. After that, a separate read of register 0 is written back as read | 0x8000.
- R5: After the reset write, register 0 is re-read while its bit 15 reads 1. The sequence moves on at the first read where bit 15 is 0.
- R6: tx_dly_en_i is sampled when start is accepted. If it is 0, the block writes 2 to register 22, then writes register 21 back as (read | 0x0020) & ~0x0010, then writes 0 to register 22. If it is 1, none of these three transactions is issued.
- R7: Register 1 is re-read until its bit 5 reads 1.
- R8: Register 19 is read exactly once after register 1 completes. If its bit 15 is 1, error_o rises and stays high, and the sequence still runs to completion.
- R9: Register 17 is re-read until its bit 11 reads 1. At that read, speed_o takes bits 15:14 (10 = 1 Gb/s, 01 = 100 Mb/s, 00 = 10 Mb/s) and done_o rises. link_up_o is done_o without an auto-negotiation error. Both hold until the next start.
- R10: Each polling loop (R5, R7, R9) issues at most POLL_MAX reads. If the condition is still unmet on the last of them, error_o rises, done_o and link_up_o stay low, and no further request is made until a new start.
- R11: A start pulse is accepted only when no sequence is running (idle, done or failed). It clears done_o, link_up_o and error_o and begins again at page selection. A start pulse that arrives during a running sequence changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse |
| tx_dly_en_i | input | 1 | 1: leave the PHY transmit clock delay on; 0: turn it off |
| req_o | output | 1 | Transaction request |
| we_o | output | 1 | 1 write, 0 read |
| phy_addr_o | output | 5 | PHY address |
| reg_addr_o | output | 5 | Register address |
| wdata_o | output | 16 | Write data |
| ack_i | input | 1 | One-cycle completion of the current transaction |
| rdata_i | input | 16 | Read data, valid with ack_i |
| done_o | output | 1 | Sequence complete, speed captured |
| error_o | output | 1 | Auto-negotiation error or poll timeout |
| link_up_o | output | 1 | Done without auto-negotiation error |
| speed_o | output | 2 | Resolved speed code |

## Verification
Two events can land in the same cycle: a new start pulse and the acknowledge of a transaction in a running sequence. The bench raises start exactly in a cycle where the PHY model acknowledges a chosen transaction. It then requires the scoreboard's expected transaction stream to continue unchanged to the end, with no second page-0 write. The other collision is a poll whose condition is met on its last permitted read. This is provoked by setting the PHY model's countdown to POLL_MAX-1, and is judged by the sequence completing instead of failing.

// File: rtl/phy_init_pkg.sv
package phy_init_pkg;
  localparam int unsigned DATA_W  = 16;
  localparam int unsigned RADDR_W = 5;
  localparam int unsigned STEP_W  = 4;

  localparam logic [RADDR_W-1:0] RA_CTRL  = 5'd0;
  localparam logic [RADDR_W-1:0] RA_STAT  = 5'd1;
  localparam logic [RADDR_W-1:0] RA_ADV   = 5'd4;
  localparam logic [RADDR_W-1:0] RA_GIG   = 5'd9;
  localparam logic [RADDR_W-1:0] RA_SPEC  = 5'd17;
  localparam logic [RADDR_W-1:0] RA_IRQ   = 5'd19;
  localparam logic [RADDR_W-1:0] RA_MACC  = 5'd21;
  localparam logic [RADDR_W-1:0] RA_PAGE  = 5'd22;

  // optional clock-delay block occupies steps DLY_FIRST..DLY_LAST
  localparam logic [STEP_W-1:0] DLY_FIRST = 4'd6;
  localparam logic [STEP_W-1:0] DLY_LAST  = 4'd8;

  typedef enum logic [2:0] {
    K_WR, K_RMW, K_POLL0, K_POLL1, K_ERR, K_SPD
  } kind_e;

  typedef struct packed {
    kind_e               kind;
    logic [RADDR_W-1:0]  addr;
    logic [DATA_W-1:0]   val;   // write value, set mask or poll mask
    logic [DATA_W-1:0]   clr;
  } step_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD, ST_WR, ST_DONE, ST_FAIL
  } st_e;
endpackage

// File: rtl/phy_init_steps.sv
module phy_init_steps
  import phy_init_pkg::*;
(
  input  logic [STEP_W-1:0] idx_i,
  output step_t             step_o
);
  always_comb begin
    step_o = '{kind: K_WR, addr: RA_PAGE, val: 16'h0000, clr: 16'h0000};
    case (idx_i)
      4'd0:  step_o = '{kind: K_WR,    addr: RA_PAGE, val: 16'h0000, clr: 16'h0000};
      4'd1:  step_o = '{kind: K_RMW,   addr: RA_ADV,  val: 16'h0DE0, clr: 16'h0000};
      4'd2:  step_o = '{kind: K_RMW,   addr: RA_GIG,  val: 16'h0300, clr: 16'h0000};
      4'd3:  step_o = '{kind: K_RMW,   addr: RA_CTRL, val: 16'h1200, clr: 16'h0000};
      4'd4:  step_o = '{kind: K_RMW,   addr: RA_CTRL, val: 16'h8000, clr: 16'h0000};
      4'd5:  step_o = '{kind: K_POLL0, addr: RA_CTRL, val: 16'h8000, clr: 16'h0000};
      4'd6:  step_o = '{kind: K_WR,    addr: RA_PAGE, val: 16'h0002, clr: 16'h0000};
      4'd7:  step_o = '{kind: K_RMW,   addr: RA_MACC, val: 16'h0020, clr: 16'h0010};
      4'd8:  step_o = '{kind: K_WR,    addr: RA_PAGE, val: 16'h0000, clr: 16'h0000};
      4'd9:  step_o = '{kind: K_POLL1, addr: RA_STAT, val: 16'h0020, clr: 16'h0000};
      4'd10: step_o = '{kind: K_ERR,   addr: RA_IRQ,  val: 16'h8000, clr: 16'h0000};
      4'd11: step_o = '{kind: K_SPD,   addr: RA_SPEC, val: 16'h0800, clr: 16'h0000};
      default: ;
    endcase
  end
endmodule

// File: rtl/phy_init_poll_timer.sv
module phy_init_poll_timer #(
  parameter int unsigned POLL_MAX = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic miss_i,
  output logic last_o
);
  localparam int unsigned CW = $clog2(POLL_MAX + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (miss_i) cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == CW'(POLL_MAX - 1));

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(POLL_MAX)); // R10
endmodule

// File: rtl/phy_init_seq.sv
module phy_init_seq
  import phy_init_pkg::*;
#(
  parameter logic [4:0]  PHY_ADDR = 5'd1,
  parameter int unsigned POLL_MAX = 1000
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                tx_dly_en_i,
  output logic                req_o,
  output logic                we_o,
  output logic [4:0]          phy_addr_o,
  output logic [RADDR_W-1:0]  reg_addr_o,
  output logic [DATA_W-1:0]   wdata_o,
  input  logic                ack_i,
  input  logic [DATA_W-1:0]   rdata_i,
  output logic                done_o,
  output logic                error_o,
  output logic                link_up_o,
  output logic [1:0]          speed_o
);
  st_e               state_q;
  logic [STEP_W-1:0] idx_q, nxt_idx, ld_idx;
  logic [DATA_W-1:0] wdata_q;
  logic              txd_q, an_err_q;
  logic [1:0]        speed_q;
  step_t             cur, nxt;

  logic idle_like, go, rd_ack, wr_ack, hit, is_poll, adv, miss, fin, last;

  phy_init_steps u_cur (.idx_i(idx_q),  .step_o(cur));
  phy_init_steps u_nxt (.idx_i(ld_idx), .step_o(nxt));

  phy_init_poll_timer #(.POLL_MAX(POLL_MAX)) u_timer (
    .clk_i, .rst_ni,
    .clr_i (go | adv | fin),
    .miss_i(miss & ~last),
    .last_o(last)
  );

  always_comb begin
    idle_like = (state_q == ST_IDLE) || (state_q == ST_DONE) || (state_q == ST_FAIL);
    go        = idle_like & start_i;
    rd_ack    = (state_q == ST_RD) & ack_i;
    wr_ack    = (state_q == ST_WR) & ack_i;
    case (cur.kind)
      K_POLL0: hit = (rdata_i & cur.val) == '0;
      K_POLL1: hit = (rdata_i & cur.val) == cur.val;
      K_SPD:   hit = rdata_i[11];
      default: hit = 1'b1;
    endcase
    is_poll = (cur.kind == K_POLL0) || (cur.kind == K_POLL1) || (cur.kind == K_SPD);
    adv     = wr_ack | (rd_ack & hit & (cur.kind != K_RMW) & (cur.kind != K_SPD));
    miss    = rd_ack & is_poll & ~hit;
    fin     = rd_ack & (cur.kind == K_SPD) & hit;
    nxt_idx = idx_q + 1'b1;
    if (txd_q && nxt_idx == DLY_FIRST) nxt_idx = DLY_LAST + 1'b1;
    ld_idx  = go ? '0 : nxt_idx;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      wdata_q  <= '0;
      txd_q    <= 1'b0;
      an_err_q <= 1'b0;
      speed_q  <= '0;
    end else if (go) begin
      state_q  <= (nxt.kind == K_WR) ? ST_WR : ST_RD;
      idx_q    <= ld_idx;
      wdata_q  <= nxt.val;
      txd_q    <= tx_dly_en_i;
      an_err_q <= 1'b0;
      speed_q  <= '0;
    end else if (adv) begin
      if (rd_ack && cur.kind == K_ERR) an_err_q <= rdata_i[15];
      state_q <= (nxt.kind == K_WR) ? ST_WR : ST_RD;
      idx_q   <= ld_idx;
      wdata_q <= nxt.val;
    end else if (fin) begin
      speed_q <= rdata_i[15:14];
      state_q <= ST_DONE;
    end else if (miss && last) begin
      state_q <= ST_FAIL;
    end else if (rd_ack && cur.kind == K_RMW) begin
      wdata_q <= (rdata_i | cur.val) & ~cur.clr;
      state_q <= ST_WR;
    end
  end

  assign req_o      = (state_q == ST_RD) || (state_q == ST_WR);
  assign we_o       = (state_q == ST_WR);
  assign phy_addr_o = PHY_ADDR;
  assign reg_addr_o = cur.addr;
  assign wdata_o    = wdata_q;
  assign done_o     = (state_q == ST_DONE);
  assign link_up_o  = done_o & ~an_err_q;
  assign error_o    = an_err_q | (state_q == ST_FAIL);
  assign speed_o    = speed_q;

  // page last written over the port, observed from the bus side
  logic [7:0] page_seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) page_seen_q <= 8'hFF;
    else if (req_o && we_o && ack_i && reg_addr_o == RA_PAGE) page_seen_q <= wdata_o[7:0];
  end

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !ack_i |=> req_o && $stable(we_o) && $stable(reg_addr_o) && $stable(wdata_o)); // R1
  AST_PAGE2_MACC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && reg_addr_o == RA_MACC |-> page_seen_q == 8'd2); // R2
  AST_PAGE0_STAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && reg_addr_o == RA_STAT |-> page_seen_q == 8'd0); // R2
  AST_DLY_SKIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && reg_addr_o == RA_MACC |-> !txd_q); // R6
  AST_DONE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> done_o && $stable(speed_o)); // R9
  AST_FAIL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o && !done_o && !req_o && !start_i |=> !req_o && error_o); // R10
  AST_BUSY_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && start_i && !ack_i |=> req_o && $stable(reg_addr_o)); // R11
endmodule

// File: tb/phy_init_seq_tb.sv
`timescale 1ns/1ps
module phy_init_seq_tb;
  localparam int PM = 6;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        tx_dly_en_i = 1'b1;
  logic        req_o, we_o, ack_i = 1'b0;
  logic [4:0]  phy_addr_o, reg_addr_o;
  logic [15:0] wdata_o, rdata_i = '0;
  logic        done_o, error_o, link_up_o;
  logic [1:0]  speed_o;

  always #5 clk = ~clk;

  phy_init_seq #(.PHY_ADDR(5'd1), .POLL_MAX(PM)) u_dut (
    .clk_i(clk), .rst_ni, .start_i, .tx_dly_en_i,
    .req_o, .we_o, .phy_addr_o, .reg_addr_o, .wdata_o,
    .ack_i, .rdata_i, .done_o, .error_o, .link_up_o, .speed_o
  );

  int checks = 0, failures = 0, ack_cnt = 0;
  bit fin_run = 1'b0;

  typedef struct { logic we; logic [4:0] ra; logic [15:0] wd; int rq; } exp_t;
  exp_t exp_q[$];

  // PHY model state
  logic [15:0] mem [32];
  int  rst_n_m = 0, rst_left = 0, an_left = 0, spd_left = 0;
  bit  err_m = 1'b0;
  logic [1:0] spd_m = 2'b00;
  int  lat = 0;

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, expv);
    end
  endtask

  task automatic push(input logic we, input logic [4:0] ra, input logic [15:0] wd, input int rq);
    exp_t e;
    e.we = we; e.ra = ra; e.wd = wd; e.rq = rq;
    exp_q.push_back(e);
  endtask

  // driver of the PHY side plus scoreboard monitor
  always @(negedge clk) begin
    if (ack_i) ack_i = 1'b0;
    else if (req_o) begin
      if (lat == 0) lat = 1;
      else begin
        exp_t e;
        lat = 0;
        ack_cnt++;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R10 unexpected transaction", {10'b0, we_o, reg_addr_o, wdata_o}, 32'h0);
        end else begin
          e = exp_q.pop_front();
          chk(we_o == e.we && reg_addr_o == e.ra && (!e.we || wdata_o == e.wd) && phy_addr_o == 5'd1,
              $sformatf("R%0d transaction", e.rq),
              {10'b0, we_o, reg_addr_o, wdata_o}, {10'b0, e.we, e.ra, e.wd});
        end
        if (we_o) begin
          mem[reg_addr_o] = wdata_o;
          if (reg_addr_o == 5'd0 && wdata_o[15]) rst_left = rst_n_m;
        end else begin
          case (reg_addr_o)
            5'd0: begin
              rdata_i = {rst_left > 0, mem[0][14:0]};
              if (rst_left > 0) rst_left--;
            end
            5'd1: begin
              rdata_i = {10'b0, an_left == 0, 5'b0};
              if (an_left > 0) an_left--;
            end
            5'd17: begin
              rdata_i = {spd_m, 2'b0, spd_left == 0, 11'b0};
              if (spd_left > 0) spd_left--;
            end
            5'd19: rdata_i = {err_m, 15'b0};
            default: rdata_i = mem[reg_addr_o];
          endcase
        end
        ack_i = 1'b1;
      end
    end
  end

  task automatic run_case(input bit txd, input logic [15:0] i0, i4, i9, i21,
                          input int n_rst, n_an, n_spd, input bit err,
                          input logic [1:0] spd, input int poke);
    bit fail, go_on;
    int n;
    for (int i = 0; i < 32; i++) mem[i] = 16'h0;
    mem[0] = i0; mem[4] = i4; mem[9] = i9; mem[21] = i21;
    rst_n_m = n_rst; rst_left = 0; an_left = n_an; spd_left = n_spd;
    err_m = err; spd_m = spd;
    fail = 1'b0; go_on = 1'b1;
    exp_q.delete();
    push(1, 5'd22, 16'h0000, 2);                   // R2 page 0 first
    push(0, 5'd4, 0, 3); push(1, 5'd4, i4 | 16'h0DE0, 3);  // R3
    push(0, 5'd9, 0, 3); push(1, 5'd9, i9 | 16'h0300, 3);  // R3
    push(0, 5'd0, 0, 4); push(1, 5'd0, i0 | 16'h1200, 4);  // R4
    push(0, 5'd0, 0, 4); push(1, 5'd0, i0 | 16'h9200, 4);  // R4
    n = (n_rst >= PM) ? PM : n_rst + 1;            // R5
    for (int i = 0; i < n; i++) push(0, 5'd0, 0, 5);
    if (n_rst >= PM) begin fail = 1'b1; go_on = 1'b0; end
    if (go_on && !txd) begin                       // R6
      push(1, 5'd22, 16'h0002, 6);
      push(0, 5'd21, 0, 6);
      push(1, 5'd21, (i21 | 16'h0020) & ~16'h0010, 6);
      push(1, 5'd22, 16'h0000, 6);
    end
    if (go_on) begin                               // R7
      n = (n_an >= PM) ? PM : n_an + 1;
      for (int i = 0; i < n; i++) push(0, 5'd1, 0, 7);
      if (n_an >= PM) begin fail = 1'b1; go_on = 1'b0; end
    end
    if (go_on) begin
      push(0, 5'd19, 0, 8);                        // R8
      n = (n_spd >= PM) ? PM : n_spd + 1;          // R9
      for (int i = 0; i < n; i++) push(0, 5'd17, 0, 9);
      if (n_spd >= PM) fail = 1'b1;
    end

    @(negedge clk);
    tx_dly_en_i = txd;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    tx_dly_en_i = ~txd;                            // must have been sampled at start
    chk(!done_o && !link_up_o && !error_o, "R11 outputs cleared after start",
        {29'b0, done_o, link_up_o, error_o}, 32'h0);

    if (poke > 0) begin                            // R11 start coincident with an ack
      int base;
      base = ack_cnt;
      for (int c = 0; c < 2000 && !(ack_i && ack_cnt == base + poke); c++) begin
        @(negedge clk); #1;
      end
      start_i = 1'b1;
      @(negedge clk); #1;
      start_i = 1'b0;
    end

    for (int c = 0; c < 5000 && exp_q.size() != 0; c++) @(negedge clk);
    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R1 all expected transactions seen", exp_q.size(), 0);
    chk(req_o == 1'b0, "R10 bus quiet at end", req_o, 0);
    if (fail) begin
      chk(error_o && !done_o && !link_up_o, "R10 timeout state",
          {29'b0, done_o, link_up_o, error_o}, 32'h1);
    end else begin
      chk(done_o == 1'b1, "R9 done", done_o, 1);
      chk(speed_o == spd, "R9 speed", speed_o, spd);
      chk(error_o == err, "R8 error flag", error_o, err);
      chk(link_up_o == !err, "R9 link_up", link_up_o, !err);
    end
  endtask

  initial begin
    for (int i = 0; i < 32; i++) mem[i] = 16'h0;
    repeat (3) @(negedge clk);
    chk(!req_o && !done_o && !error_o && !link_up_o && speed_o == 2'b00, "R11 reset state",
        {27'b0, req_o, done_o, error_o, link_up_o, speed_o != 0}, 32'h0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk(req_o == 1'b0, "R11 idle without start", req_o, 0);

    // delay option on, 1 Gb/s, a few polls
    run_case(1'b1, 16'h0140, 16'h0001, 16'h0000, 16'h0000, 2, 3, 1, 1'b0, 2'b10, 0);
    // delay option off, AN error, 100 Mb/s, busy start on 5th ack
    run_case(1'b0, 16'h0040, 16'h0C1F, 16'h0400, 16'h0458, 0, 0, 0, 1'b1, 2'b01, 5);
    // reset bit never clears
    run_case(1'b1, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 100, 0, 0, 1'b0, 2'b10, 0);
    // restart from failed state, each poll met on its last allowed read, 10 Mb/s
    run_case(1'b0, 16'h1000, 16'hFFFF, 16'h00FF, 16'h0030, PM-1, PM-1, PM-1, 1'b0, 2'b00, 0);
    // auto-negotiation never completes
    run_case(1'b0, 16'h0000, 16'h0000, 16'h0000, 16'h0030, 1, 100, 0, 1'b0, 2'b10, 0);
    // speed never resolves
    run_case(1'b1, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 0, 0, 100, 1'b0, 2'b10, 0);
    // restart after failure, done again
    run_case(1'b1, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 0, 1, 2, 1'b0, 2'b01, 0);

    fin_run = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!fin_run) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule